// File: doc/BRIEF.md
# Transmit Packet Ready Notifier

This block decides when an outgoing asynchronous packet that is being loaded into the transmit FIFO may be announced to the link layer. It watches how many quadlets of the current packet are already stored and whether the whole packet has been loaded. It raises a registered packet-available flag once enough data is buffered that the link cannot run dry during transmission. The notify level is programmable in steps of 16 quadlets. A separate option makes a retried packet wait until the largest level has been reached, so a packet that underran on its first attempt gets more margin on the retry.

Software loads two settings with a write strobe: the step count and the retry-maximum option. The loaded step count is clamped to the largest legal value. Once the flag is raised it stays up until the link acknowledges that transmission has started. The notifier then holds off until the FIFO side reports an empty count for the current packet, so the packet just acknowledged can never be announced a second time.

Top module: `tx_ready_notifier`

## Requirements
- R1: After a synchronous reset, pkt_avail is 0, the loaded step count is 16 (a 256-quadlet level) and the retry-maximum option is off.
- R2: With the option not in effect, pkt_avail goes to 1 on the clock edge after fill_cnt is non-zero and at least 16 times the loaded step count.
- R3: pkt_avail goes to 1 on the clock edge after pkt_complete is 1 with a non-zero fill_cnt, even when fill_cnt is below the level.
- R4: A step count above 32 loaded through cfg_n acts as 32, which gives a 512-quadlet level.
- R5: While retry is 1 and the loaded retry-maximum option is 1, the level is 512 quadlets whatever step count is loaded.
- R6: While the retry-maximum option is 0, a packet with retry at 1 uses the same level as a packet with retry at 0.
- R7: Once pkt_avail is 1, it stays 1 until link_ack is 1 at a clock edge, and it is 0 after that edge even if the ready condition still holds.
- R8: After an acknowledged notification, pkt_avail stays 0 until fill_cnt has been 0 at a clock edge. link_ack while pkt_avail is 0 has no effect.
- R9: A fill_cnt of 0 never raises pkt_avail, including with a step count of 0.
- R10: cfg_n and cfg_retry_max are loaded only on a clock edge where cfg_wr is 1. Changes to them at other times leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load strobe for cfg_n and cfg_retry_max |
| cfg_n | input | 6 | Step count; level is 16 quadlets per step |
| cfg_retry_max | input | 1 | Retry-maximum option value to load |
| fill_cnt | input | 10 | Quadlets of the current packet held in the FIFO |
| pkt_complete | input | 1 | Whole current packet is in the FIFO |
| retry | input | 1 | Current packet is a retransmission |
| link_ack | input | 1 | Link has started transmitting the announced packet |
| pkt_avail | output | 1 | Registered packet-available flag |

## Verification
Two events can fall in the same cycle: a link acknowledge and a freshly satisfied ready condition. If the flag is already up, the acknowledge wins and the flag drops even though the fill count stays above the level. If the flag is down, the acknowledge is ignored and the flag rises. Both cases are set up by driving link_ack together with a fill count at or above the level. The flag is then sampled on the following edge against the value the bench computes from the flag's previous state. A sweep over every step count from 0 to 40, both retry values and both option values checks counts just below and at each level, as well as small complete packets.

// File: rtl/tx_notify_pkg.sv
package tx_notify_pkg;

  typedef enum logic [1:0] {
    NS_IDLE    = 2'd0,
    NS_NOTIFY  = 2'd1,
    NS_HOLDOFF = 2'd2
  } notify_state_e;

  typedef struct packed {
    logic [5:0] step_n;
    logic       retry_max;
  } notify_cfg_t;

  localparam logic [5:0] RESET_STEP_N = 6'd16;

endpackage

// File: rtl/tx_notify_cfg.sv
module tx_notify_cfg
  import tx_notify_pkg::*;
#(
  parameter int N_W      = 6,
  parameter int STEP_CAP = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [N_W-1:0] n_in,
  input  logic           retry_max_in,
  output logic [N_W-1:0] n_q,
  output logic           retry_max_q
);

  localparam logic [N_W-1:0] CAP_N = N_W'(STEP_CAP);

  logic [N_W-1:0] n_clamped;

  always_comb begin
    n_clamped = (n_in > CAP_N) ? CAP_N : n_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q         <= N_W'(RESET_STEP_N);
      retry_max_q <= 1'b0;
    end else if (wr) begin
      n_q         <= n_clamped;
      retry_max_q <= retry_max_in;
    end
  end

endmodule

// File: rtl/tx_notify_level.sv
module tx_notify_level #(
  parameter int N_W      = 6,
  parameter int CNT_W    = 10,
  parameter int STEP_Q   = 16,
  parameter int STEP_CAP = 32
) (
  input  logic [N_W-1:0]  n_cfg,
  input  logic            retry_max,
  input  logic            retry,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic            pkt_complete,
  output logic            ready
);

  localparam int LVL_W = CNT_W + 1;
  localparam bit STEP_POW2 = (STEP_Q & (STEP_Q - 1)) == 0;
  localparam int STEP_SH = $clog2(STEP_Q);

  logic [N_W-1:0]   n_eff;
  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] fill_ext;

  always_comb begin
    n_eff = (retry && retry_max) ? N_W'(STEP_CAP) : n_cfg;
  end

  generate
    if (STEP_POW2) begin : g_shift
      always_comb level = LVL_W'(n_eff) << STEP_SH;
    end else begin : g_mult
      always_comb level = LVL_W'(n_eff) * LVL_W'(STEP_Q);
    end
  endgenerate

  always_comb begin
    fill_ext = LVL_W'(fill_cnt);
    ready    = (fill_cnt != '0) && (pkt_complete || (fill_ext >= level));
  end

endmodule

// File: rtl/tx_notify_fsm.sv
module tx_notify_fsm
  import tx_notify_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic             link_ack,
  input  logic [CNT_W-1:0] fill_cnt,
  output logic             avail
);

  notify_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      NS_IDLE:    if (ready) state_d = NS_NOTIFY;
      NS_NOTIFY:  if (link_ack) state_d = NS_HOLDOFF;
      NS_HOLDOFF: if (fill_cnt == '0) state_d = NS_IDLE;
      default:    state_d = NS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= NS_IDLE;
      avail   <= 1'b0;
    end else begin
      state_q <= state_d;
      avail   <= (state_d == NS_NOTIFY);
    end
  end

endmodule

// File: rtl/tx_ready_notifier.sv
module tx_ready_notifier
  import tx_notify_pkg::*;
#(
  parameter int N_W      = 6,
  parameter int CNT_W    = 10,
  parameter int STEP_Q   = 16,
  parameter int STEP_CAP = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [N_W-1:0]   cfg_n,
  input  logic             cfg_retry_max,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic             pkt_complete,
  input  logic             retry,
  input  logic             link_ack,
  output logic             pkt_avail
);

  logic [N_W-1:0] n_q;
  logic           retry_max_q;
  logic           ready;

  tx_notify_cfg #(
    .N_W      (N_W),
    .STEP_CAP (STEP_CAP)
  ) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .wr           (cfg_wr),
    .n_in         (cfg_n),
    .retry_max_in (cfg_retry_max),
    .n_q          (n_q),
    .retry_max_q  (retry_max_q)
  );

  tx_notify_level #(
    .N_W      (N_W),
    .CNT_W    (CNT_W),
    .STEP_Q   (STEP_Q),
    .STEP_CAP (STEP_CAP)
  ) u_level (
    .n_cfg        (n_q),
    .retry_max    (retry_max_q),
    .retry        (retry),
    .fill_cnt     (fill_cnt),
    .pkt_complete (pkt_complete),
    .ready        (ready)
  );

  tx_notify_fsm #(
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .link_ack (link_ack),
    .fill_cnt (fill_cnt),
    .avail    (pkt_avail)
  );

endmodule

// File: rtl/tx_ready_notifier_chk.sv
module tx_ready_notifier_chk #(
  parameter int N_W      = 6,
  parameter int CNT_W    = 10,
  parameter int STEP_Q   = 16,
  parameter int STEP_CAP = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [N_W-1:0]   cfg_n,
  input logic             cfg_retry_max,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             pkt_complete,
  input logic             retry,
  input logic             link_ack,
  input logic             pkt_avail
);

  int unsigned sh_n;
  logic        sh_rmax;
  logic        sh_block;
  int unsigned sh_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_n     <= 16;
      sh_rmax  <= 1'b0;
    end else if (cfg_wr) begin
      sh_n     <= (int'(cfg_n) > STEP_CAP) ? STEP_CAP : int'(cfg_n);
      sh_rmax  <= cfg_retry_max;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sh_block <= 1'b0;
    else if (pkt_avail && link_ack) sh_block <= 1'b1;
    else if (fill_cnt == '0) sh_block <= 1'b0;
  end

  always_comb begin
    sh_level = (retry && sh_rmax) ? STEP_CAP * STEP_Q : sh_n * STEP_Q;
  end

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    pkt_avail && link_ack |=> !pkt_avail); // R7

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    pkt_avail && !link_ack |=> pkt_avail); // R7

  AST_NO_EMPTY_NOTIFY: assert property (@(posedge clk) disable iff (rst)
    !pkt_avail && fill_cnt == '0 |=> !pkt_avail); // R9

  AST_LEVEL_MET: assert property (@(posedge clk) disable iff (rst)
    !pkt_avail && !sh_block && fill_cnt != '0
      && (pkt_complete || int'(fill_cnt) >= sh_level) |=> pkt_avail); // R2

  AST_LEVEL_NOT_MET: assert property (@(posedge clk) disable iff (rst)
    !pkt_avail && !pkt_complete && int'(fill_cnt) < sh_level |=> !pkt_avail); // R5

  AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    sh_block && fill_cnt != '0 |=> !pkt_avail); // R8

endmodule

bind tx_ready_notifier tx_ready_notifier_chk #(
  .N_W      (N_W),
  .CNT_W    (CNT_W),
  .STEP_Q   (STEP_Q),
  .STEP_CAP (STEP_CAP)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_wr        (cfg_wr),
  .cfg_n         (cfg_n),
  .cfg_retry_max (cfg_retry_max),
  .fill_cnt      (fill_cnt),
  .pkt_complete  (pkt_complete),
  .retry         (retry),
  .link_ack      (link_ack),
  .pkt_avail     (pkt_avail)
);

// File: tb/tx_ready_notifier_bench.sv
module tx_ready_notifier_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [5:0] cfg_n = '0;
  logic       cfg_retry_max = 1'b0;
  logic [9:0] fill_cnt = '0;
  logic       pkt_complete = 1'b0;
  logic       retry = 1'b0;
  logic       link_ack = 1'b0;
  logic       pkt_avail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_ready_notifier u_tx_ready_notifier (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_n         (cfg_n),
    .cfg_retry_max (cfg_retry_max),
    .fill_cnt      (fill_cnt),
    .pkt_complete  (pkt_complete),
    .retry         (retry),
    .link_ack      (link_ack),
    .pkt_avail     (pkt_avail)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pkt_avail=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one clock: inputs already set at negedge, sample at the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cfg(input int n, input bit rmax);
    cfg_n = 6'(n);
    cfg_retry_max = rmax;
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  // ack any outstanding flag and drain the count so the notifier is idle
  task automatic settle();
    link_ack = pkt_avail;
    tick();
    link_ack = 1'b0;
    fill_cnt = '0;
    pkt_complete = 1'b0;
    tick();
  endtask

  function automatic int level_of(input int n, input bit rt, input bit rmax);
    int nc;
    nc = (n > 32) ? 32 : n;
    if (rt && rmax) nc = 32;
    return nc * 16;
  endfunction

  task automatic trial(input string req, input int f, input bit c, input bit rt,
                       input int lvl);
    logic exp;
    settle();
    fill_cnt = 10'(f);
    pkt_complete = c;
    retry = rt;
    exp = (f != 0) && (c || f >= lvl);
    tick();
    check(req, pkt_avail, exp);
    if (exp) begin
      link_ack = 1'b1;
      tick();
      link_ack = 1'b0;
      check("R7", pkt_avail, 1'b0);
      tick();
      check("R8", pkt_avail, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", pkt_avail, 1'b0);

    // R1: reset level 256, retry-max off
    trial("R1", 255, 1'b0, 1'b0, 256);
    trial("R1", 256, 1'b0, 1'b0, 256);
    trial("R1", 256, 1'b0, 1'b1, 256);

    // R10: inputs changed without the strobe
    settle();
    cfg_n = 6'd1;
    cfg_retry_max = 1'b1;
    trial("R10", 100, 1'b0, 1'b1, 256);

    // sweep every step count, retry and option
    for (int n = 0; n <= 40; n++) begin
      for (int rm = 0; rm < 2; rm++) begin
        load_cfg(n, bit'(rm));
        for (int rt = 0; rt < 2; rt++) begin
          int lvl;
          string rq;
          lvl = level_of(n, bit'(rt), bit'(rm));
          if (rt == 1 && rm == 1) rq = "R5";
          else if (rt == 1) rq = "R6";
          else if (n > 32) rq = "R4";
          else rq = "R2";
          if (lvl > 1) trial(rq, lvl - 1, 1'b0, bit'(rt), lvl);
          if (lvl > 0) trial(rq, lvl, 1'b0, bit'(rt), lvl);
          trial("R3", 3, 1'b1, bit'(rt), lvl);
          trial("R9", 0, 1'b0, bit'(rt), lvl);
        end
      end
    end

    // collisions: ready with ack at the same edge
    load_cfg(2, 1'b0);
    settle();
    retry = 1'b0;
    fill_cnt = 10'd40;
    link_ack = 1'b1;
    tick();
    check("R8", pkt_avail, 1'b1);
    tick();
    check("R8", pkt_avail, 1'b0);
    link_ack = 1'b0;
    tick();
    check("R8", pkt_avail, 1'b0);
    fill_cnt = '0;
    tick();
    fill_cnt = 10'd40;
    tick();
    check("R8", pkt_avail, 1'b1);
    repeat (5) tick();
    check("R7", pkt_avail, 1'b1);
    fill_cnt = '0;
    tick();
    check("R7", pkt_avail, 1'b1);
    settle();
    check("R7", pkt_avail, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: finished=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule